// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block is the trap-entry side of a processor's system-control coprocessor. When the pipeline raises an exception it presents a cause code, the PC of the faulting instruction, a delay-slot flag, a coprocessor number, a faulting data address, the miss type from the TLB and the eight pending interrupt lines. On one clock edge the block updates its saved-PC, status, cause and bad-address registers and issues a one-cycle redirect with the handler address. It also performs the status pop on a return-from-exception strobe, and reports when an interrupt may be taken.

The status register holds a two-level mode stack. Bit 0 is the current interrupt enable. Bit 1 is the current user flag, where 0 means kernel mode. Bits 3:2 and 5:4 hold the older levels. Bit 22 selects the boot-time vector base, and bits 15:8 hold the interrupt mask. The surrounding logic can load the whole status register through a write port.

A breakpoint does not enter a handler. It raises a sticky halt output and leaves every register as it was.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On a non-breakpoint entry, the saved PC is the presented PC minus 4 and cause bit 31 is 1 when the delay-slot flag is set. Otherwise the saved PC is the presented PC and cause bit 31 is 0.
- R2: A non-breakpoint entry clears status bits 1:0 and leaves every other status bit unchanged.
- R3: A non-breakpoint entry clears cause bits 31, 29:28, 15:8 and 6:2. It then writes the code into bits 6:2 and the pending interrupt lines into bits 15:8.
- R4: For code 11 (coprocessor unusable), cause bits 29:28 take the coprocessor number. For any other code they read 0.
- R5: For code 4 or 5 (address error on load or store), the bad-address register loads the faulting address. Other codes leave it unchanged.
- R6: The handler base is 0xBFC00100 when status bit 22 is 1, and 0x80000000 when it is 0.
- R7: The handler offset is 0x000 for code 2 or 3 (TLB miss on load or store) when the miss-from-user input is 1, and 0x080 otherwise.
- R8: Code 9 (breakpoint) sets the halt output, which stays set until reset. It changes no register and produces no redirect.
- R9: A return strobe replaces status bits 3:0 with the old bits 5:2 and keeps bits 31:4.
- R10: The interrupt output is 1 exactly when status bit 0 is 1 and status bits 15:8 are nonzero.
- R11: All register updates and the redirect pulse appear together on the clock edge after the entry strobe. The redirect is valid for exactly one cycle.
- R12: Reset gives status 0x00400000, all other registers 0, and halt and redirect low. When several strobes arrive together, entry wins over return, and return wins over a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | Exception entry strobe |
| exc_code | input | 5 | Exception cause code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_cop | input | 2 | Coprocessor number for a coprocessor-unusable fault |
| exc_bad_addr | input | 32 | Faulting data address for address errors |
| miss_from_user | input | 1 | TLB reports that the miss came from user mode |
| int_pending | input | 8 | Pending interrupt lines |
| rfe_req | input | 1 | Return-from-exception strobe |
| sr_wr_en | input | 1 | Status register write strobe |
| sr_wr_data | input | 32 | Status write value |
| epc_q | output | 32 | Saved PC |
| status_q | output | 32 | Status register |
| cause_q | output | 32 | Cause register |
| badvaddr_q | output | 32 | Bad-address register |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | Handler address |
| halt | output | 1 | Sticky breakpoint halt |
| irq_take | output | 1 | Interrupt may be taken |

## Verification
The bench sends a delay-slot fault right after a normal one. A design that forgot the minus-4 correction or the BD bit would return to the wrong instruction. It follows a coprocessor-unusable fault with a different code, so a design that failed to clear the coprocessor field would leave a stale number in cause. It covers all four vector combinations of boot base and user TLB miss, including a TLB store miss from kernel mode that must take the general offset. It checks that a breakpoint leaves the saved PC and status untouched and raises no redirect. The return pop is tested with distinct bit patterns so that a shift in the wrong direction or a clobbered upper field shows up.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 5;
  localparam int IP_W   = 8;
  localparam int COP_W  = 2;

  localparam logic [CODE_W-1:0] C_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] C_TLBS = 5'd3;
  localparam logic [CODE_W-1:0] C_ADEL = 5'd4;
  localparam logic [CODE_W-1:0] C_ADES = 5'd5;
  localparam logic [CODE_W-1:0] C_BRK  = 5'd9;
  localparam logic [CODE_W-1:0] C_CPU  = 5'd11;

  localparam int SR_IE   = 0;
  localparam int SR_KU   = 1;
  localparam int SR_BEV  = 22;
  localparam int IP_LO   = 8;
  localparam int CE_LO   = 28;
  localparam int CODE_LO = 2;
  localparam int BD_BIT  = 31;

  function automatic logic [XLEN-1:0] saved_pc(input logic [XLEN-1:0] pc, input logic dly);
    return dly ? pc - XLEN'(4) : pc;
  endfunction

  function automatic logic [XLEN-1:0] sr_pop(input logic [XLEN-1:0] sr);
    return {sr[XLEN-1:4], sr[5:2]};
  endfunction

  function automatic logic is_user_miss(input logic [CODE_W-1:0] c, input logic usr);
    return usr && (c == C_TLBL || c == C_TLBS);
  endfunction
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC0_0100,
  parameter logic [XLEN-1:0] RUN_BASE  = 32'h8000_0000,
  parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0080
) (
  input  logic              bev,
  input  logic              user_miss,
  output logic [XLEN-1:0]   vec
);
  logic [XLEN-1:0] base;
  always_comb begin
    base = bev ? BOOT_BASE : RUN_BASE;
    vec  = base + (user_miss ? '0 : GEN_OFS);
  end
endmodule

// File: rtl/exc_sr_unit.sv
module exc_sr_unit
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] SR_RESET = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  logic            pop,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] sr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= SR_RESET;
    end else if (enter) begin
      sr[SR_IE] <= 1'b0;
      sr[SR_KU] <= 1'b0;
    end else if (pop) begin
      sr <= sr_pop(sr);
    end else if (wr_en) begin
      sr <= wr_data;
    end
  end
endmodule

// File: rtl/exc_cause_unit.sv
module exc_cause_unit
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   pc,
  input  logic              dly,
  input  logic [COP_W-1:0]  cop,
  input  logic [XLEN-1:0]   bad_addr,
  input  logic [IP_W-1:0]   pend,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   cause,
  output logic [XLEN-1:0]   badv
);
  logic [XLEN-1:0] cause_nx;
  logic            addr_err;

  always_comb begin
    addr_err = (code == C_ADEL) || (code == C_ADES);
    cause_nx = cause;
    cause_nx[BD_BIT] = dly;
    cause_nx[CE_LO +: COP_W] = (code == C_CPU) ? cop : '0;
    cause_nx[IP_LO +: IP_W] = pend;
    cause_nx[CODE_LO +: CODE_W] = code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
      badv  <= '0;
    end else if (enter) begin
      epc   <= saved_pc(pc, dly);
      cause <= cause_nx;
      if (addr_err) badv <= bad_addr;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] SR_RESET  = 32'h0040_0000,
  parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC0_0100,
  parameter logic [XLEN-1:0] RUN_BASE  = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_req,
  input  logic [4:0]  exc_code,
  input  logic [31:0] exc_pc,
  input  logic        exc_in_delay,
  input  logic [1:0]  exc_cop,
  input  logic [31:0] exc_bad_addr,
  input  logic        miss_from_user,
  input  logic [7:0]  int_pending,
  input  logic        rfe_req,
  input  logic        sr_wr_en,
  input  logic [31:0] sr_wr_data,
  output logic [31:0] epc_q,
  output logic [31:0] status_q,
  output logic [31:0] cause_q,
  output logic [31:0] badvaddr_q,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic        halt,
  output logic        irq_take
);
  logic            is_brk;
  logic            do_enter;
  logic            do_pop;
  logic [XLEN-1:0] vec;

  assign is_brk   = exc_req && (exc_code == C_BRK);
  assign do_enter = exc_req && !is_brk;
  assign do_pop   = rfe_req && !exc_req;
  assign irq_take = status_q[SR_IE] && (|status_q[IP_LO +: IP_W]);

  exc_vec_sel #(.BOOT_BASE(BOOT_BASE), .RUN_BASE(RUN_BASE)) u_vec (
    .bev(status_q[SR_BEV]),
    .user_miss(is_user_miss(exc_code, miss_from_user)),
    .vec(vec)
  );

  exc_sr_unit #(.SR_RESET(SR_RESET)) u_sr (
    .clk(clk), .rst_n(rst_n), .enter(do_enter), .pop(do_pop),
    .wr_en(sr_wr_en), .wr_data(sr_wr_data), .sr(status_q)
  );

  exc_cause_unit u_cause (
    .clk(clk), .rst_n(rst_n), .enter(do_enter), .code(exc_code),
    .pc(exc_pc), .dly(exc_in_delay), .cop(exc_cop), .bad_addr(exc_bad_addr),
    .pend(int_pending), .epc(epc_q), .cause(cause_q), .badv(badvaddr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      halt           <= 1'b0;
    end else begin
      redirect_valid <= do_enter;
      if (do_enter) redirect_pc <= vec;
      if (is_brk) halt <= 1'b1;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_req,
  input logic [4:0]  exc_code,
  input logic [31:0] exc_pc,
  input logic        exc_in_delay,
  input logic [7:0]  int_pending,
  input logic        rfe_req,
  input logic [31:0] epc_q,
  input logic [31:0] status_q,
  input logic [31:0] cause_q,
  input logic        redirect_valid,
  input logic [31:0] redirect_pc,
  input logic        halt
);
  // R1
  p_delay_epc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_code != 5'd9 && exc_in_delay) |=>
      (epc_q == $past(exc_pc) - 32'd4) && cause_q[31]);
  // R2
  p_kernel_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_code != 5'd9) |=>
      (status_q[1:0] == 2'b00) && (status_q[31:2] == $past(status_q[31:2])));
  // R3
  p_code_ip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_code != 5'd9) |=>
      (cause_q[6:2] == $past(exc_code)) && (cause_q[15:8] == $past(int_pending)));
  // R8
  p_brk_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_code == 5'd9 && !rfe_req) |=>
      halt && !redirect_valid && $stable(epc_q) && $stable(cause_q) && $stable(status_q));
  // R9
  p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_req && !exc_req) |=>
      (status_q[3:0] == $past(status_q[5:2])) && (status_q[31:4] == $past(status_q[31:4])));
  // R6, R7
  p_vec_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_pc[31:8] == 24'h800000 || redirect_pc[31:8] == 24'hBFC001)
                       && (redirect_pc[7:0] == 8'h00 || redirect_pc[7:0] == 8'h80));
  // R11
  p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !$past(exc_req)) |-> 1'b0);
  // R8
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |=> halt);
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
  .exc_pc(exc_pc), .exc_in_delay(exc_in_delay), .int_pending(int_pending),
  .rfe_req(rfe_req), .epc_q(epc_q), .status_q(status_q), .cause_q(cause_q),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .halt(halt)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  localparam time TCLK = 10ns;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        exc_req = 0;
  logic [4:0]  exc_code = 0;
  logic [31:0] exc_pc = 0;
  logic        exc_in_delay = 0;
  logic [1:0]  exc_cop = 0;
  logic [31:0] exc_bad_addr = 0;
  logic        miss_from_user = 0;
  logic [7:0]  int_pending = 0;
  logic        rfe_req = 0;
  logic        sr_wr_en = 0;
  logic [31:0] sr_wr_data = 0;
  logic [31:0] epc_q, status_q, cause_q, badvaddr_q, redirect_pc;
  logic        redirect_valid, halt, irq_take;

  int n_chk = 0;
  int n_err = 0;

  always #(TCLK/2) clk = ~clk;

  exc_entry_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_sr(input logic [31:0] v);
    @(negedge clk); sr_wr_en = 1; sr_wr_data = v;
    @(negedge clk); sr_wr_en = 0;
  endtask

  task automatic enter(input logic [4:0] c, input logic [31:0] pc, input logic d,
                       input logic [1:0] cop, input logic [31:0] ba,
                       input logic usr, input logic [7:0] pend);
    @(negedge clk);
    exc_req = 1; exc_code = c; exc_pc = pc; exc_in_delay = d; exc_cop = cop;
    exc_bad_addr = ba; miss_from_user = usr; int_pending = pend;
    @(negedge clk);
    exc_req = 0; exc_in_delay = 0;
  endtask

  task automatic t_reset;
    chk("R12 status", status_q, 32'h0040_0000);
    chk("R12 epc", epc_q, 0);
    chk("R12 cause", cause_q, 0);
    chk("R12 halt/redir", {30'd0, halt, redirect_valid}, 0);
  endtask

  task automatic t_irq;
    wr_sr(32'h0000_FF03); chk("R10 enabled", irq_take, 1);
    wr_sr(32'h0000_FF02); chk("R10 ie off", irq_take, 0);
    wr_sr(32'h0000_0001); chk("R10 mask zero", irq_take, 0);
    wr_sr(32'h0000_FF03);
  endtask

  task automatic t_plain;
    enter(5'd1, 32'h0000_1000, 0, 0, 0, 0, 8'hA5);
    chk("R11 redirect pulse", redirect_valid, 1);
    chk("R1 epc", epc_q, 32'h0000_1000);
    chk("R3 cause", cause_q, 32'h0000_A504);
    chk("R2 status", status_q, 32'h0000_FF00);
    chk("R7 general offset", redirect_pc, 32'h8000_0080);
    @(negedge clk);
    chk("R11 single cycle", redirect_valid, 0);
  endtask

  task automatic t_delay;
    enter(5'd0, 32'h0000_2004, 1, 0, 0, 0, 8'h01);
    chk("R1 delay epc", epc_q, 32'h0000_2000);
    chk("R1 BD set", cause_q, 32'h8000_0100);
  endtask

  task automatic t_cpu;
    enter(5'd11, 32'h0000_3000, 0, 2'd2, 0, 0, 8'h00);
    chk("R4 ce field", cause_q, 32'h2000_002C);
    enter(5'd1, 32'h0000_3004, 0, 2'd3, 0, 0, 8'h00);
    chk("R4 ce cleared", cause_q, 32'h0000_0004);
  endtask

  task automatic t_badaddr;
    enter(5'd5, 32'h0000_4000, 0, 0, 32'hDEAD_0001, 0, 0);
    chk("R5 badvaddr load", badvaddr_q, 32'hDEAD_0001);
    enter(5'd1, 32'h0000_4004, 0, 0, 32'h1111_2222, 0, 0);
    chk("R5 badvaddr kept", badvaddr_q, 32'hDEAD_0001);
  endtask

  task automatic t_vectors;
    wr_sr(32'h0000_0000);
    enter(5'd2, 32'h100, 0, 0, 0, 1, 0);
    chk("R7 user miss run base", redirect_pc, 32'h8000_0000);
    enter(5'd3, 32'h104, 0, 0, 0, 0, 0);
    chk("R7 kernel miss general", redirect_pc, 32'h8000_0080);
    wr_sr(32'h0040_0000);
    enter(5'd3, 32'h108, 0, 0, 0, 1, 0);
    chk("R6 boot user miss", redirect_pc, 32'hBFC0_0100);
    enter(5'd1, 32'h10C, 0, 0, 0, 1, 0);
    chk("R6 boot general", redirect_pc, 32'hBFC0_0180);
  endtask

  task automatic t_brk;
    wr_sr(32'h0000_0013);
    enter(5'd9, 32'h0000_9000, 1, 0, 32'h5, 0, 8'hFF);
    chk("R8 halt", halt, 1);
    chk("R8 no redirect", redirect_valid, 0);
    chk("R8 epc kept", epc_q, 32'h0000_010C);
    chk("R8 status kept", status_q, 32'h0000_0013);
    chk("R8 cause kept", cause_q, 32'h0000_0004);
  endtask

  task automatic t_rfe;
    wr_sr(32'h0000_FF3C);
    @(negedge clk); rfe_req = 1; @(negedge clk); rfe_req = 0;
    chk("R9 pop ones", status_q, 32'h0000_FF3F);
    wr_sr(32'h1234_5628);
    @(negedge clk); rfe_req = 1; @(negedge clk); rfe_req = 0;
    chk("R9 pop pattern", status_q, 32'h1234_562A);
    @(negedge clk); rfe_req = 1; sr_wr_en = 1; sr_wr_data = 32'hFFFF_FFFF;
    exc_req = 1; exc_code = 5'd1; exc_pc = 32'h50;
    @(negedge clk); rfe_req = 0; sr_wr_en = 0; exc_req = 0;
    chk("R12 entry priority", status_q, 32'h1234_5628);
    @(negedge clk); rfe_req = 1; sr_wr_en = 1; sr_wr_data = 32'hFFFF_FFFF;
    @(negedge clk); rfe_req = 0; sr_wr_en = 0;
    chk("R12 return over write", status_q, 32'h1234_562A);
  endtask

  initial begin
    #(TCLK * 50000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_irq();
    t_plain();
    t_delay();
    t_cpu();
    t_badaddr();
    t_vectors();
    t_brk();
    t_rfe();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule